// File: doc/BRIEF.md
# Emergency Halt Flag Controller

This block supervises two active-low emergency inputs of a motion controller: a travel-limit input and a stop input. Each input passes through a synchronizer and sets a sticky internal flag when it is seen low. The flags drive the controller's mode logic. A set limit flag requests a fall-back to the idle mode, holds the motor command cleared, and blocks requests to leave idle. The mode bits that record which control loop was selected are left untouched. A set stop flag matters only in the integral velocity mode. There it latches a zero-velocity hold, which the velocity loop follows with a decelerated stop.

A flag is released by a two-step handshake. The input must first read high again. Then software must write to the status register. Any value written releases the flag, and the low nibble of the same write loads the status configuration bits. A write made while the input is still low is dropped. It is not kept for later. The zero-velocity hold ends only after the stop flag has been released and a fresh velocity command has then been written.

Top module: `halt_flag_ctrl`

## Requirements
- R1: A low level on `lim_n_i` or `stp_n_i` sets the matching flag output (`lim_flag_o`, `stp_flag_o`) at the third rising clock edge after it is applied (two synchronizer stages, then the flag register).
- R2: While the synchronized input is low, its flag stays set whatever is written. A status write made while the input was low leaves the flag set after the input returns high.
- R3: A status write (`stat_wr_i` high with `stat_addr_i` equal to 7) with any data clears every flag whose synchronized input is high, at the next edge. Writes to other addresses clear nothing.
- R4: A status write loads `stat_data_i[3:0]` into `stat_cfg_o` at the next edge. Writes to other addresses leave `stat_cfg_o` unchanged.
- R5: `force_idle_o` is high one edge after a cycle in which the limit flag is set and `mode_i` is not idle (mode code 0), and low otherwise.
- R6: `mc_clr_o` is high exactly one edge after each cycle in which the limit flag is set.
- R7: `mode_flags_o` repeats `mode_flags_i` one edge later whatever the state of the limit flag.
- R8: `run_ok_o` is high one edge after a cycle with `run_req_i` high and the limit flag clear. It is low whenever the limit flag was set.
- R9: `zero_vel_o` goes high one edge after a cycle in which the stop flag is set and `mode_i` is the integral velocity mode (code 4). A stop flag in any other mode does not raise it.
- R10: Once high, `zero_vel_o` stays high until a cycle with `vel_wr_i` high and the stop flag clear. It falls at the next edge.
- R11: During reset, both flags, `stat_cfg_o` and every effect output are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_n_i | input | 1 | Limit emergency input, active low, asynchronous |
| stp_n_i | input | 1 | Stop emergency input, active low, asynchronous |
| stat_wr_i | input | 1 | Register write strobe |
| stat_addr_i | input | 4 | Register write address (status register is 7) |
| stat_data_i | input | 8 | Register write data |
| mode_i | input | 3 | Current controller mode (0 idle, 4 integral velocity) |
| mode_flags_i | input | 3 | Current control-mode flag bits |
| run_req_i | input | 1 | Request to leave the idle mode |
| vel_wr_i | input | 1 | New velocity command written |
| lim_flag_o | output | 1 | Latched limit flag |
| stp_flag_o | output | 1 | Latched stop flag |
| force_idle_o | output | 1 | Request to enter the idle mode |
| mc_clr_o | output | 1 | Hold the motor command at zero |
| run_ok_o | output | 1 | Leave-idle request granted |
| zero_vel_o | output | 1 | Command velocity held at zero |
| mode_flags_o | output | 3 | Control-mode flags, never cleared by this block |
| stat_cfg_o | output | 4 | Status configuration nibble |

## Verification
An input level reaches its flag at the third edge. The limit effects and the zero-velocity hold follow one edge after the flag. Write-driven results (flag release, configuration nibble) and the pass-through outputs appear at the first edge. The bench keeps a cycle-level model that advances on the same rising edge as the design, with the synchronizer delay written out as two model stages. It compares every output at the falling edge, after both have settled. Directed sequences cover a write held back while an input is still low, a stop outside the integral velocity mode, and a velocity write made before the stop flag has cleared. Seeded random traffic covers the rest.

// File: rtl/halt_pkg.sv
package halt_pkg;
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_LIM  = 0;
  localparam int FLAG_STP  = 1;

  localparam int MODE_W     = 3;
  localparam int CTL_FLAG_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_IDLE = 3'd0,
    MODE_POS  = 3'd1,
    MODE_PVEL = 3'd2,
    MODE_TRAP = 3'd3,
    MODE_IVEL = 3'd4
  } ctl_mode_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  // reset to the idle-high level so no false emergency appears
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/emerg_flag.sv
module emerg_flag (
  input  logic clk,
  input  logic rst,
  input  logic pin_ok_i,
  input  logic clr_hit_i,
  output logic flag_o
);
  // set dominates; release needs a healthy pin in the same cycle as the write
  always_ff @(posedge clk) begin
    if (rst)            flag_o <= 1'b0;
    else if (!pin_ok_i) flag_o <= 1'b1;
    else if (clr_hit_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/stat_cfg_reg.sv
module stat_cfg_reg #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CFG_W     = 4,
  parameter int STAT_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o,
  output logic [CFG_W-1:0]  cfg_o
);
  logic unused_hi;
  assign unused_hi = ^data_i[DATA_W-1:CFG_W];

  assign hit_o = wr_i && (addr_i == ADDR_W'(STAT_ADDR));

  always_ff @(posedge clk) begin
    if (rst)        cfg_o <= '0;
    else if (hit_o) cfg_o <= data_i[CFG_W-1:0];
  end
endmodule

// File: rtl/mode_effects.sv
module mode_effects #(
  parameter int MODE_W     = 3,
  parameter int CTL_FLAG_W = 3,
  parameter int IDLE_CODE  = 0,
  parameter int IVEL_CODE  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lim_flag_i,
  input  logic                  stp_flag_i,
  input  logic [MODE_W-1:0]     mode_i,
  input  logic [CTL_FLAG_W-1:0] mode_flags_i,
  input  logic                  run_req_i,
  input  logic                  vel_wr_i,
  output logic                  force_idle_o,
  output logic                  mc_clr_o,
  output logic                  run_ok_o,
  output logic                  zero_vel_o,
  output logic [CTL_FLAG_W-1:0] mode_flags_o
);
  logic in_idle, in_ivel, hold_set, hold_rel;

  assign in_idle  = (mode_i == MODE_W'(IDLE_CODE));
  assign in_ivel  = (mode_i == MODE_W'(IVEL_CODE));
  assign hold_set = stp_flag_i && in_ivel;
  assign hold_rel = vel_wr_i && !stp_flag_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      force_idle_o <= 1'b0;
      mc_clr_o     <= 1'b0;
      run_ok_o     <= 1'b0;
      zero_vel_o   <= 1'b0;
      mode_flags_o <= '0;
    end else begin
      force_idle_o <= lim_flag_i && !in_idle;
      mc_clr_o     <= lim_flag_i;
      run_ok_o     <= run_req_i && !lim_flag_i;
      zero_vel_o   <= hold_set || (zero_vel_o && !hold_rel);
      mode_flags_o <= mode_flags_i;
    end
  end
endmodule

// File: rtl/halt_flag_ctrl.sv
module halt_flag_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int CFG_W       = 4,
  parameter int STAT_ADDR   = 7
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            lim_n_i,
  input  logic                            stp_n_i,
  input  logic                            stat_wr_i,
  input  logic [ADDR_W-1:0]               stat_addr_i,
  input  logic [DATA_W-1:0]               stat_data_i,
  input  logic [halt_pkg::MODE_W-1:0]     mode_i,
  input  logic [halt_pkg::CTL_FLAG_W-1:0] mode_flags_i,
  input  logic                            run_req_i,
  input  logic                            vel_wr_i,
  output logic                            lim_flag_o,
  output logic                            stp_flag_o,
  output logic                            force_idle_o,
  output logic                            mc_clr_o,
  output logic                            run_ok_o,
  output logic                            zero_vel_o,
  output logic [halt_pkg::CTL_FLAG_W-1:0] mode_flags_o,
  output logic [CFG_W-1:0]                stat_cfg_o
);
  import halt_pkg::*;

  logic [NUM_FLAGS-1:0] pin_raw, pin_ok, flag_q;
  logic                 stat_hit;

  assign pin_raw[FLAG_LIM] = lim_n_i;
  assign pin_raw[FLAG_STP] = stp_n_i;

  pin_sync #(.W(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (pin_raw), .q_o (pin_ok)
  );

  stat_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .STAT_ADDR(STAT_ADDR)
  ) u_stat (
    .clk (clk), .rst (rst), .wr_i (stat_wr_i), .addr_i (stat_addr_i),
    .data_i (stat_data_i), .hit_o (stat_hit), .cfg_o (stat_cfg_o)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    emerg_flag u_flag (
      .clk (clk), .rst (rst), .pin_ok_i (pin_ok[g]),
      .clr_hit_i (stat_hit), .flag_o (flag_q[g])
    );
  end

  assign lim_flag_o = flag_q[FLAG_LIM];
  assign stp_flag_o = flag_q[FLAG_STP];

  mode_effects #(
    .MODE_W(MODE_W), .CTL_FLAG_W(CTL_FLAG_W),
    .IDLE_CODE(int'(MODE_IDLE)), .IVEL_CODE(int'(MODE_IVEL))
  ) u_fx (
    .clk (clk), .rst (rst),
    .lim_flag_i (flag_q[FLAG_LIM]), .stp_flag_i (flag_q[FLAG_STP]),
    .mode_i (mode_i), .mode_flags_i (mode_flags_i),
    .run_req_i (run_req_i), .vel_wr_i (vel_wr_i),
    .force_idle_o (force_idle_o), .mc_clr_o (mc_clr_o),
    .run_ok_o (run_ok_o), .zero_vel_o (zero_vel_o),
    .mode_flags_o (mode_flags_o)
  );
endmodule

// File: rtl/halt_flag_chk.sv
module halt_flag_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CFG_W     = 4,
  parameter int STAT_ADDR = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              stat_wr_i,
  input logic [ADDR_W-1:0] stat_addr_i,
  input logic [DATA_W-1:0] stat_data_i,
  input logic [2:0]        mode_i,
  input logic [2:0]        mode_flags_i,
  input logic              run_req_i,
  input logic              vel_wr_i,
  input logic              lim_flag_o,
  input logic              stp_flag_o,
  input logic              mc_clr_o,
  input logic              run_ok_o,
  input logic              zero_vel_o,
  input logic [2:0]        mode_flags_o,
  input logic [CFG_W-1:0]  stat_cfg_o
);
  logic hit;
  assign hit = stat_wr_i && (stat_addr_i == ADDR_W'(STAT_ADDR));

  // R3
  lim_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lim_flag_o) |-> $past(hit));
  // R3
  stp_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stp_flag_o) |-> $past(hit));
  // R4
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> stat_cfg_o == $past(stat_data_i[CFG_W-1:0]));
  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(stat_cfg_o));
  // R6
  mc_clr_chk: assert property (@(posedge clk) disable iff (rst)
    lim_flag_o |=> mc_clr_o);
  // R7
  mode_flags_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mode_flags_o == $past(mode_flags_i));
  // R8
  run_block_chk: assert property (@(posedge clk) disable iff (rst)
    lim_flag_o |=> !run_ok_o);
  // R9
  zero_set_chk: assert property (@(posedge clk) disable iff (rst)
    (stp_flag_o && mode_i == 3'd4) |=> zero_vel_o);
  // R10
  zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_vel_o && !(vel_wr_i && !stp_flag_o)) |=> zero_vel_o);
  // R8
  run_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (run_req_i && !lim_flag_o) |=> run_ok_o);
endmodule

bind halt_flag_ctrl halt_flag_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk (clk), .rst (rst), .stat_wr_i (stat_wr_i), .stat_addr_i (stat_addr_i),
  .stat_data_i (stat_data_i), .mode_i (mode_i), .mode_flags_i (mode_flags_i),
  .run_req_i (run_req_i), .vel_wr_i (vel_wr_i), .lim_flag_o (lim_flag_o),
  .stp_flag_o (stp_flag_o), .mc_clr_o (mc_clr_o), .run_ok_o (run_ok_o),
  .zero_vel_o (zero_vel_o), .mode_flags_o (mode_flags_o),
  .stat_cfg_o (stat_cfg_o)
);

// File: tb/sim_halt_flag_ctrl.sv
`timescale 1ns/1ps
module sim_halt_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lim_n = 1'b1, stp_n = 1'b1;
  logic       swr = 1'b0;
  logic [3:0] saddr = '0;
  logic [7:0] sdata = '0;
  logic [2:0] mode = '0, mflags = '0;
  logic       rreq = 1'b0, vwr = 1'b0;
  logic       lim_f, stp_f, fidle, mclr, rok, zvel;
  logic [2:0] mflags_o;
  logic [3:0] cfg;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  halt_flag_ctrl u0 (
    .clk (clk), .rst (rst), .lim_n_i (lim_n), .stp_n_i (stp_n),
    .stat_wr_i (swr), .stat_addr_i (saddr), .stat_data_i (sdata),
    .mode_i (mode), .mode_flags_i (mflags), .run_req_i (rreq), .vel_wr_i (vwr),
    .lim_flag_o (lim_f), .stp_flag_o (stp_f), .force_idle_o (fidle),
    .mc_clr_o (mclr), .run_ok_o (rok), .zero_vel_o (zvel),
    .mode_flags_o (mflags_o), .stat_cfg_o (cfg)
  );

  // reference model built from the requirements
  logic [1:0] m_ls, m_ss;
  logic       m_lim, m_stp, m_fidle, m_mclr, m_rok, m_zvel;
  logic [2:0] m_mf;
  logic [3:0] m_cfg;

  function automatic logic f_flag(logic cur, logic pin_ok, logic hit);
    if (!pin_ok) return 1'b1;
    if (hit)     return 1'b0;
    return cur;
  endfunction

  function automatic logic f_hold(logic cur, logic stp, logic [2:0] md, logic vw);
    return (stp && md == 3'd4) || (cur && !(vw && !stp));
  endfunction

  always @(posedge clk) begin
    logic hit;
    hit = swr && saddr == 4'd7;
    if (rst) begin
      m_ls <= 2'b11; m_ss <= 2'b11; m_lim <= 0; m_stp <= 0;
      m_fidle <= 0; m_mclr <= 0; m_rok <= 0; m_zvel <= 0; m_mf <= 0; m_cfg <= 0;
    end else begin
      m_ls    <= {m_ls[0], lim_n};
      m_ss    <= {m_ss[0], stp_n};
      m_lim   <= f_flag(m_lim, m_ls[1], hit);
      m_stp   <= f_flag(m_stp, m_ss[1], hit);
      if (hit) m_cfg <= sdata[3:0];
      m_fidle <= m_lim && mode != 3'd0;
      m_mclr  <= m_lim;
      m_rok   <= rreq && !m_lim;
      m_zvel  <= f_hold(m_zvel, m_stp, mode, vwr);
      m_mf    <= mflags;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1/R2/R3", "lim_flag", lim_f, m_lim);
    chk("R1/R2/R3", "stp_flag", stp_f, m_stp);
    chk("R4", "stat_cfg", cfg, m_cfg);
    chk("R5", "force_idle", fidle, m_fidle);
    chk("R6", "mc_clr", mclr, m_mclr);
    chk("R7", "mode_flags", mflags_o, m_mf);
    chk("R8", "run_ok", rok, m_rok);
    chk("R9/R10", "zero_vel", zvel, m_zvel);
  endtask

  // one cycle: compare at falling edge, then drive the next inputs
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic idle_bus();
    swr = 0; vwr = 0; rreq = 0;
  endtask

  task automatic stat_write(logic [3:0] a, logic [7:0] d);
    swr = 1; saddr = a; sdata = d;
    step();
    swr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "lim_flag rst", lim_f, 0);
    chk("R11", "stp_flag rst", stp_f, 0);
    chk("R11", "cfg rst", cfg, 0);
    chk("R11", "outs rst", {fidle, mclr, rok, zvel}, 0);
    rst = 0;
    step(2);

    // R1: limit low reaches the flag on the third edge
    mode = 3'd3; mflags = 3'b101;
    lim_n = 0;
    step(2);
    chk("R1", "lim not yet", lim_f, 0);
    step();
    chk("R1", "lim set third edge", lim_f, 1);
    step();
    chk("R5", "force idle", fidle, 1);
    chk("R6", "mc clear", mclr, 1);
    chk("R7", "mode flags kept", mflags_o, 3'b101);
    rreq = 1; step(); rreq = 0;
    chk("R8", "run blocked", rok, 0);
    // R2: write while still low is ignored and not remembered
    stat_write(4'd7, 8'hA3);
    chk("R2", "lim held during write", lim_f, 1);
    chk("R4", "cfg loaded", cfg, 4'h3);
    lim_n = 1;
    step(5);
    chk("R2", "lim held after pin high", lim_f, 1);
    // R3: wrong address does not release
    stat_write(4'd6, 8'hFF);
    chk("R3", "wrong addr keeps lim", lim_f, 1);
    chk("R4", "wrong addr keeps cfg", cfg, 4'h3);
    stat_write(4'd7, 8'h5C);
    chk("R3", "lim released", lim_f, 0);
    chk("R4", "cfg reload", cfg, 4'hC);
    mode = 3'd0; step(2);
    chk("R5", "no force once clear", fidle, 0);

    // R9: stop outside integral velocity mode has no effect
    mode = 3'd2; stp_n = 0;
    step(5);
    chk("R9", "stop in other mode", zvel, 0);
    mode = 3'd4; step(2);
    chk("R9", "stop in ivel", zvel, 1);
    stp_n = 1; step(3);
    // R10: velocity write while flag set does not release
    vwr = 1; step(); vwr = 0;
    chk("R10", "vel write before clear", zvel, 1);
    stat_write(4'd7, 8'h00);
    chk("R3", "stp released", stp_f, 0);
    step(2);
    chk("R10", "hold kept until vel write", zvel, 1);
    vwr = 1; step(); vwr = 0;
    chk("R10", "hold released", zvel, 0);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(15) == 0) lim_n = ~lim_n;
      if ($urandom_range(15) == 0) stp_n = ~stp_n;
      swr   = ($urandom_range(5) == 0);
      saddr = ($urandom_range(1) == 0) ? 4'd7 : 4'($urandom_range(15));
      sdata = 8'($urandom());
      if ($urandom_range(19) == 0) mode = 3'($urandom_range(4));
      mflags = 3'($urandom());
      rreq  = 1'($urandom());
      vwr   = ($urandom_range(7) == 0);
      step();
    end
    idle_bus();
    step(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule